// File: doc/BRIEF.md
# Dual-Slope Global Shutter Exposure Sequencer

This block drives the pixel-array control pulses of a global-shutter image sensor for one exposure. One `start` pulse in idle launches a fixed chain of phases. First comes the main reset pulse. Next comes the integration window, in which up to four lower-level secondary reset pulses can be placed to give a multi-slope response. After that, the memory level is switched, the sample pulse is issued and the precharge pulse is issued. The block then returns to idle and pulses `done` for one cycle.

Every phase length comes from a configuration input, counted in clock cycles. Each length is raised to at least `MIN_W` cycles, because the on-chip drivers settle slowly (about 200 ns). The default of 50 cycles covers that time at a 250 MHz clock.

The outputs are plain logic-level controls with their final polarity. Sample and precharge are active low. Both resets are active high. The memory select is low while the memory level is switched. All controls are plain pins with no handshake. The configuration must stay stable while `busy` is high.

Top module: `exp_seq_top`

## Requirements
- R1: After reset, `precharge_n`=1, `sample_n`=1, `reset_p`=0, `reset_ds_p`=0, `mem_hl`=1, `busy`=0 and `done`=0.
- R2: A `start` high at a clock edge while idle makes `busy` high after that edge and leads to exactly one main reset pulse.
- R3: The phases follow each other back to back, in this order: `reset_p` high, the integration window, `mem_hl` low, `sample_n` low, then `precharge_n` low. `done` is high for exactly one cycle, in the cycle right after the precharge pulse ends, and `busy` then returns low.
- R4: The main reset, integration, memory, sample, precharge and secondary-reset lengths each equal the larger of the programmed value and `MIN_W` cycles.
- R5: Integration cycle t counts from 0, where cycle 0 is the first cycle after `reset_p` falls. Slot i is taken from `cfg_ds_off[i*W_INT +: W_INT]` and is enabled when i < `cfg_ds_cnt`. An enabled slot drives `reset_ds_p` high for cycles off_i to off_i+L_ds-1. The pulse is cut at the end of the window, and overlapping slots merge into one pulse.
- R6: A slot with an offset at or beyond the integration length, or with an index at or above `cfg_ds_cnt`, produces no pulse.
- R7: `reset_ds_p` is never high in the same cycle as `reset_p`, because the main reset dominates. It is never high outside the integration window.
- R8: A `start` that arrives while `busy` is high is ignored: no further reset pulse and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one exposure cycle (sampled in idle only) |
| cfg_rst_w | input | W_PW | Main reset width in cycles |
| cfg_int_len | input | W_INT | Integration length in cycles |
| cfg_ds_w | input | W_PW | Secondary reset width in cycles |
| cfg_ds_cnt | input | $clog2(N_DS+1) | Number of enabled secondary reset slots |
| cfg_ds_off | input | N_DS*W_INT | Secondary reset offsets, slot 0 in the low bits |
| cfg_mem_w | input | W_PW | Memory-level phase width in cycles |
| cfg_smp_w | input | W_PW | Sample pulse width in cycles |
| cfg_pre_w | input | W_PW | Precharge pulse width in cycles |
| precharge_n | output | 1 | Precharge control, active low |
| sample_n | output | 1 | Sample control, active low |
| reset_p | output | 1 | Main reset control, active high |
| reset_ds_p | output | 1 | Secondary reset control, active high |
| mem_hl | output | 1 | Memory level select, 0 selects the low level |
| busy | output | 1 | Exposure cycle in progress |
| done | output | 1 | One-cycle pulse at the end of a cycle |

## Verification
A phase counter that is off by one shows at once as a pulse that is one cycle too long or too short. It also shows as a gap or an overlap between two adjacent phases, visible in the same cycle that the phase boundary is reached. A wrong slot comparison in the secondary-reset scheduler shows as a `reset_ds_p` edge that lies away from its programmed integration cycle, so it is seen during the integration window and not only at `done`. A stuck phase state shows as a missing `done`, and the bench catches this with a bounded wait for each run.

// File: rtl/exp_seq_pkg.sv
`timescale 1ns/1ps
package exp_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RST  = 3'd1,
    PH_INT  = 3'd2,
    PH_MEM  = 3'd3,
    PH_SMP  = 3'd4,
    PH_PRE  = 3'd5,
    PH_DONE = 3'd6
  } phase_t;
endpackage

// File: rtl/exp_phase_ctrl.sv
`timescale 1ns/1ps
// Phase sequencer: walks reset -> integration -> memory -> sample -> precharge.
module exp_phase_ctrl
  import exp_seq_pkg::*;
#(
  parameter int W_CNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W_CNT-1:0] len_rst,
  input  logic [W_CNT-1:0] len_int,
  input  logic [W_CNT-1:0] len_mem,
  input  logic [W_CNT-1:0] len_smp,
  input  logic [W_CNT-1:0] len_pre,
  output phase_t           phase,
  output logic [W_CNT-1:0] tick
);
  logic [W_CNT-1:0] cur_len;
  phase_t           nxt_phase;

  always_comb begin
    cur_len   = len_rst;
    nxt_phase = PH_IDLE;
    unique case (phase)
      PH_RST:  begin cur_len = len_rst; nxt_phase = PH_INT;  end
      PH_INT:  begin cur_len = len_int; nxt_phase = PH_MEM;  end
      PH_MEM:  begin cur_len = len_mem; nxt_phase = PH_SMP;  end
      PH_SMP:  begin cur_len = len_smp; nxt_phase = PH_PRE;  end
      PH_PRE:  begin cur_len = len_pre; nxt_phase = PH_DONE; end
      default: begin cur_len = len_rst; nxt_phase = PH_IDLE; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      tick  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          tick <= '0;
          if (start) phase <= PH_RST;
        end
        PH_DONE: begin
          tick  <= '0;
          phase <= PH_IDLE;
        end
        default: begin
          if (tick == cur_len - 1'b1) begin
            tick  <= '0;
            phase <= nxt_phase;
          end else begin
            tick <= tick + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/exp_ds_sched.sv
`timescale 1ns/1ps
// Secondary reset scheduler: one comparator window per offset slot.
module exp_ds_sched #(
  parameter int N_DS  = 4,
  parameter int W_CNT = 16,
  parameter int W_SEL = 3
) (
  input  logic                  in_int,
  input  logic [W_CNT-1:0]      tick,
  input  logic [W_CNT-1:0]      len_int,
  input  logic [W_CNT-1:0]      ds_len,
  input  logic [W_SEL-1:0]      ds_cnt,
  input  logic [N_DS*W_CNT-1:0] offs,
  output logic                  ds_req
);
  logic [N_DS-1:0] hit;

  for (genvar g = 0; g < N_DS; g++) begin : g_slot
    logic [W_CNT-1:0] off;
    logic             slot_en;
    logic [W_CNT:0]   stop;
    assign off     = offs[g*W_CNT +: W_CNT];
    assign slot_en = (g < int'(ds_cnt)) && (off < len_int);
    assign stop    = {1'b0, off} + {1'b0, ds_len};
    assign hit[g]  = in_int && slot_en && (tick >= off) && ({1'b0, tick} < stop);
  end

  assign ds_req = |hit;
endmodule

// File: rtl/exp_out_stage.sv
`timescale 1ns/1ps
// Registered output stage: final polarities and main-reset dominance.
module exp_out_stage
  import exp_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  input  logic   ds_req,
  output logic   precharge_n,
  output logic   sample_n,
  output logic   reset_p,
  output logic   reset_ds_p,
  output logic   mem_hl,
  output logic   done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      precharge_n <= 1'b1;
      sample_n    <= 1'b1;
      reset_p     <= 1'b0;
      reset_ds_p  <= 1'b0;
      mem_hl      <= 1'b1;
      done        <= 1'b0;
    end else begin
      precharge_n <= (phase != PH_PRE);
      sample_n    <= (phase != PH_SMP);
      reset_p     <= (phase == PH_RST);
      reset_ds_p  <= ds_req && (phase != PH_RST);
      mem_hl      <= (phase != PH_MEM);
      done        <= (phase == PH_DONE);
    end
  end
endmodule

// File: rtl/exp_seq_top.sv
`timescale 1ns/1ps
module exp_seq_top
  import exp_seq_pkg::*;
#(
  parameter int N_DS  = 4,
  parameter int W_PW  = 8,
  parameter int W_INT = 16,
  parameter int MIN_W = 50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [W_PW-1:0]         cfg_rst_w,
  input  logic [W_INT-1:0]        cfg_int_len,
  input  logic [W_PW-1:0]         cfg_ds_w,
  input  logic [$clog2(N_DS+1)-1:0] cfg_ds_cnt,
  input  logic [N_DS*W_INT-1:0]   cfg_ds_off,
  input  logic [W_PW-1:0]         cfg_mem_w,
  input  logic [W_PW-1:0]         cfg_smp_w,
  input  logic [W_PW-1:0]         cfg_pre_w,
  output logic                    precharge_n,
  output logic                    sample_n,
  output logic                    reset_p,
  output logic                    reset_ds_p,
  output logic                    mem_hl,
  output logic                    busy,
  output logic                    done
);
  localparam int               W_SEL = $clog2(N_DS + 1);
  localparam logic [W_INT-1:0] MIN_L = W_INT'(MIN_W);

  logic [W_INT-1:0] raw_rst, raw_ds, raw_mem, raw_smp, raw_pre;
  logic [W_INT-1:0] len_rst, len_int, len_ds, len_mem, len_smp, len_pre;
  phase_t           phase;
  logic [W_INT-1:0] tick;
  logic             ds_req;

  assign raw_rst = W_INT'(cfg_rst_w);
  assign raw_ds  = W_INT'(cfg_ds_w);
  assign raw_mem = W_INT'(cfg_mem_w);
  assign raw_smp = W_INT'(cfg_smp_w);
  assign raw_pre = W_INT'(cfg_pre_w);

  // settle-time floor on every programmed length
  assign len_rst = (raw_rst     < MIN_L) ? MIN_L : raw_rst;
  assign len_int = (cfg_int_len < MIN_L) ? MIN_L : cfg_int_len;
  assign len_ds  = (raw_ds      < MIN_L) ? MIN_L : raw_ds;
  assign len_mem = (raw_mem     < MIN_L) ? MIN_L : raw_mem;
  assign len_smp = (raw_smp     < MIN_L) ? MIN_L : raw_smp;
  assign len_pre = (raw_pre     < MIN_L) ? MIN_L : raw_pre;

  exp_phase_ctrl #(.W_CNT(W_INT)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .len_rst (len_rst),
    .len_int (len_int),
    .len_mem (len_mem),
    .len_smp (len_smp),
    .len_pre (len_pre),
    .phase   (phase),
    .tick    (tick)
  );

  exp_ds_sched #(.N_DS(N_DS), .W_CNT(W_INT), .W_SEL(W_SEL)) u_sched (
    .in_int  (phase == PH_INT),
    .tick    (tick),
    .len_int (len_int),
    .ds_len  (len_ds),
    .ds_cnt  (cfg_ds_cnt),
    .offs    (cfg_ds_off),
    .ds_req  (ds_req)
  );

  exp_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .ds_req      (ds_req),
    .precharge_n (precharge_n),
    .sample_n    (sample_n),
    .reset_p     (reset_p),
    .reset_ds_p  (reset_ds_p),
    .mem_hl      (mem_hl),
    .done        (done)
  );

  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/exp_seq_chk.sv
`timescale 1ns/1ps
module exp_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic precharge_n,
  input logic sample_n,
  input logic reset_p,
  input logic reset_ds_p,
  input logic mem_hl
);
  // R1
  idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (precharge_n && sample_n && !reset_p && !reset_ds_p && mem_hl));

  // R7
  reset_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_p |-> !reset_ds_p);

  // R7
  ds_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_ds_p |-> (busy && mem_hl && sample_n && precharge_n));

  // R3
  sample_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_n) |-> $past(!mem_hl));

  // R3
  pre_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(precharge_n) |-> $past(!sample_n));

  // R3
  done_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!precharge_n));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  launch_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_p) |-> $past(!busy, 2));
endmodule

bind exp_seq_top exp_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .precharge_n (precharge_n),
  .sample_n    (sample_n),
  .reset_p     (reset_p),
  .reset_ds_p  (reset_ds_p),
  .mem_hl      (mem_hl)
);

// File: tb/sim_exp_seq_top.sv
`timescale 1ns/1ps
module sim_exp_seq_top;
  localparam int N_DS  = 4;
  localparam int W_PW  = 8;
  localparam int W_INT = 16;
  localparam int MIN_W = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W_PW-1:0]  cfg_rst_w = '0, cfg_ds_w = '0, cfg_mem_w = '0, cfg_smp_w = '0, cfg_pre_w = '0;
  logic [W_INT-1:0] cfg_int_len = '0;
  logic [2:0]       cfg_ds_cnt = '0;
  logic [N_DS*W_INT-1:0] cfg_ds_off = '0;
  logic precharge_n, sample_n, reset_p, reset_ds_p, mem_hl, busy, done;

  always #2 clk = ~clk;

  exp_seq_top #(.N_DS(N_DS), .W_PW(W_PW), .W_INT(W_INT), .MIN_W(MIN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_rst_w(cfg_rst_w), .cfg_int_len(cfg_int_len), .cfg_ds_w(cfg_ds_w),
    .cfg_ds_cnt(cfg_ds_cnt), .cfg_ds_off(cfg_ds_off), .cfg_mem_w(cfg_mem_w),
    .cfg_smp_w(cfg_smp_w), .cfg_pre_w(cfg_pre_w),
    .precharge_n(precharge_n), .sample_n(sample_n), .reset_p(reset_p),
    .reset_ds_p(reset_ds_p), .mem_hl(mem_hl), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // port monitor, sampled on falling edges
  int cyc = 0;
  int t_rst_on, t_rst_off, t_mem_on, t_mem_off, t_smp_on, t_smp_off, t_pre_on, t_pre_off, t_done;
  int n_done, n_rst_on, ds_out, both, ti;
  bit in_int;
  bit obs [0:2047];
  bit p_rst = 0, p_mem = 1, p_smp = 1, p_pre = 1;

  always @(negedge clk) begin
    cyc++;
    if (reset_p && !p_rst) begin t_rst_on = cyc; n_rst_on++; end
    if (!reset_p && p_rst) begin t_rst_off = cyc; in_int = 1; ti = 0; end
    if (!mem_hl && p_mem) begin t_mem_on = cyc; in_int = 0; end
    if (mem_hl && !p_mem) t_mem_off = cyc;
    if (!sample_n && p_smp) t_smp_on = cyc;
    if (sample_n && !p_smp) t_smp_off = cyc;
    if (!precharge_n && p_pre) t_pre_on = cyc;
    if (precharge_n && !p_pre) t_pre_off = cyc;
    if (done) begin t_done = cyc; n_done++; end
    if (in_int) begin
      if (ti < 2048) obs[ti] = reset_ds_p;
      ti++;
    end else if (reset_ds_p) ds_out++;
    if (reset_p && reset_ds_p) both++;
    p_rst = reset_p; p_mem = mem_hl; p_smp = sample_n; p_pre = precharge_n;
  end

  function automatic int flr(input int v);
    return (v < MIN_W) ? MIN_W : v;
  endfunction

  task automatic run_seq(input int rw, input int iw, input int mw, input int sw, input int pw,
                         input int dw, input int dc, input int o0, input int o1,
                         input int o2, input int o3, input bit poke);
    int offs [4];
    int li, ld, mism, first_bad;
    offs = '{o0, o1, o2, o3};
    n_done = 0; n_rst_on = 0; ds_out = 0; both = 0; in_int = 0;
    for (int k = 0; k < 2048; k++) obs[k] = 0;
    cfg_rst_w = W_PW'(rw); cfg_int_len = W_INT'(iw); cfg_mem_w = W_PW'(mw);
    cfg_smp_w = W_PW'(sw); cfg_pre_w = W_PW'(pw); cfg_ds_w = W_PW'(dw);
    cfg_ds_cnt = 3'(dc);
    cfg_ds_off = {W_INT'(o3), W_INT'(o2), W_INT'(o1), W_INT'(o0)};
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    check("R2", "busy after start", int'(busy), 1);
    for (int i = 0; i < 20000 && n_done == 0; i++) begin
      @(negedge clk);
      if (poke && (i == 5 || i == 150 || i == 400)) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    if (poke) repeat (400) @(negedge clk);
    li = flr(iw); ld = flr(dw);
    check("R3", "done seen", n_done, 1);
    check("R2", "reset pulses", n_rst_on, 1);
    check("R4", "reset width", t_rst_off - t_rst_on, flr(rw));
    check("R4", "integration length", t_mem_on - t_rst_off, li);
    check("R4", "memory width", t_mem_off - t_mem_on, flr(mw));
    check("R4", "sample width", t_smp_off - t_smp_on, flr(sw));
    check("R4", "precharge width", t_pre_off - t_pre_on, flr(pw));
    check("R3", "sample follows memory", t_smp_on, t_mem_off);
    check("R3", "precharge follows sample", t_pre_on, t_smp_off);
    check("R3", "done after precharge", t_done, t_pre_off);
    check("R3", "busy low at end", int'(busy), 0);
    check("R7", "ds outside window", ds_out, 0);
    check("R7", "ds with main reset", both, 0);
    mism = 0; first_bad = -1;
    for (int t = 0; t < li; t++) begin
      bit e = 0;
      for (int s = 0; s < 4; s++)
        if (s < dc && offs[s] < li && t >= offs[s] && t < offs[s] + ld) e = 1;
      if (e != obs[t]) begin
        mism++;
        if (first_bad < 0) first_bad = t;
      end
    end
    if (mism != 0) $display("  first ds mismatch at integration cycle %0d", first_bad);
    check("R5", "ds schedule mismatches", mism, 0);
  endtask

  task automatic test_reset_state();
    check("R1", "precharge_n", int'(precharge_n), 1);
    check("R1", "sample_n", int'(sample_n), 1);
    check("R1", "reset_p", int'(reset_p), 0);
    check("R1", "reset_ds_p", int'(reset_ds_p), 0);
    check("R1", "mem_hl", int'(mem_hl), 1);
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
  endtask

  // R2 R3: plain sequence, no secondary pulses
  task automatic test_plain();
    run_seq(60, 200, 70, 55, 80, 60, 0, 10, 20, 30, 40, 1'b0);
  endtask

  // R4: every length below the floor
  task automatic test_min_floor();
    run_seq(1, 5, 0, 10, 49, 2, 1, 0, 0, 0, 0, 1'b0);
  endtask

  // R5: two separated secondary pulses
  task automatic test_dual();
    run_seq(55, 300, 60, 60, 60, 60, 2, 20, 150, 0, 0, 1'b0);
  endtask

  // R5: four slots, overlap merge and truncation at window end
  task automatic test_multi_overlap();
    run_seq(55, 300, 60, 60, 60, 50, 4, 10, 40, 200, 280, 1'b0);
  endtask

  // R6: offset beyond window and slots beyond the count are dropped
  task automatic test_ignored();
    run_seq(55, 300, 60, 60, 60, 50, 2, 400, 100, 30, 60, 1'b0);
    check("R6", "ds pulses inside window only from slot 1", int'(obs[30]), 0);
  endtask

  // R8: start pokes during a running cycle
  task automatic test_busy_start();
    run_seq(60, 250, 60, 60, 60, 50, 1, 70, 0, 0, 0, 1'b1);
    check("R8", "no relaunch reset pulses", n_rst_on, 1);
    check("R8", "single done", n_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset_state();
    test_plain();
    test_min_floor();
    test_dual();
    test_multi_overlap();
    test_ignored();
    test_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule